// File: doc/BRIEF.md
# RTC Extension Control Register

This block is the 8-bit extension control register of a real-time clock that software reaches over a two-wire serial bus. It holds the fields that pick the alarm comparison target, the tick of the time-update interrupt, the enable of the fixed-cycle countdown timer and that timer's source clock. It also holds a factory test bit. The bus engine hands the block a one-cycle write strobe with a data byte, and pulses that mark a bus STOP, a repeated START and a bus timeout of about 0.95 s. The block drives each field out as its own signal and returns the whole register as a read-back byte.

A stray write of 1 to the test bit must not leave the clock in test mode. Any of the three bus events therefore forces the test bit back to 0. The event changes only that bit. Bits 3 and 2 are not implemented. They ignore writes and always read as 0.

Top module: `rtcExtCtrlReg`

## Requirements
- R1: While reset is asserted, and after it is released with no write yet, every field output is 0 and rdData reads 8'h00.
- R2: If wrEn is high at a rising clock edge, bits 7, 6, 5, 4, 1 and 0 of wrData all load into the register at that edge. rdData and the field outputs show the new value from that edge on.
- R3: Bits 3 and 2 of rdData are always 0, whatever value is written to them.
- R4: If wrEn is low and no bus event is pulsed at an edge, rdData holds its value across that edge.
- R5: A busStop pulse at an edge clears the test bit (bit 7) at that edge. Bits 6 to 0 are left as they were.
- R6: A busRestart pulse at an edge clears the test bit at that edge. Bits 6 to 0 are left as they were.
- R7: A busTimeout pulse at an edge clears the test bit at that edge. Bits 6 to 0 are left as they were.
- R8: If a write and a bus event arrive at the same edge, the test bit becomes 0. Bits 6, 5, 4, 1 and 0 still take the written data.
- R9: The field outputs follow the register bits. testMode is bit 7. alarmDaySel is bit 6, where 1 compares day-of-month and 0 compares day-of-week. updateMinute is bit 5, where 1 gives a minute tick and 0 gives a second tick. timerRun is bit 4. timerSrc[1:0] is bits 1:0, where 00 selects 4096 Hz, 01 selects 64 Hz, 10 selects a second update and 11 selects a minute update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle register write strobe |
| wrData | input | 8 | Write data byte |
| busStop | input | 1 | Pulse marking a bus STOP condition |
| busRestart | input | 1 | Pulse marking a bus repeated START |
| busTimeout | input | 1 | Pulse marking the bus timeout expiring |
| testMode | output | 1 | Factory test bit |
| alarmDaySel | output | 1 | Alarm target: 1 day-of-month, 0 day-of-week |
| updateMinute | output | 1 | Update tick: 1 minute, 0 second |
| timerRun | output | 1 | Countdown timer enable |
| timerSrc | output | 2 | Countdown timer source select |
| rdData | output | 8 | Read-back value of the register |

## Verification
Every result here comes from a single register stage. A write or a bus event applied before a rising edge is visible at the outputs right after that edge. The bench drives its stimulus on the falling edge and lets one rising edge pass. It then samples at the next falling edge, which is half a cycle after the result settles. The hold and ignore cases are checked at that same falling edge, after an edge with no write or event, by reading rdData and the field outputs.

// File: rtl/rtcExtPkg.sv
package rtcExtPkg;
  localparam int REG_W      = 8;
  localparam int TEST_BIT   = 7;
  localparam int DAYSEL_BIT = 6;
  localparam int MINUTE_BIT = 5;
  localparam int RUN_BIT    = 4;
  localparam int SRC_LSB    = 0;
  localparam int SRC_W      = 2;
  localparam int NUM_EVT    = 3;
  localparam logic [REG_W-1:0] WRITE_MASK = 8'hF3;

  typedef struct packed {
    logic load;
    logic clearTest;
  } ctrlStrobe_t;
endpackage

// File: rtl/rtcExtCtrl.sv
module rtcExtCtrl
  import rtcExtPkg::*;
#(
  parameter int EVT_N = NUM_EVT
) (
  input  logic             wrEn,
  input  logic [EVT_N-1:0] busEvt,
  output ctrlStrobe_t      strb
);
  logic [EVT_N:0] evtChain;

  assign evtChain[0] = 1'b0;
  for (genvar e = 0; e < EVT_N; e++) begin : g_evt
    assign evtChain[e+1] = evtChain[e] | busEvt[e];
  end

  always_comb begin
    strb.load      = wrEn;
    strb.clearTest = evtChain[EVT_N];
  end
endmodule

// File: rtl/rtcExtData.sv
module rtcExtData
  import rtcExtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] regQ
);
  logic [REG_W-1:0] regNext;

  always_comb begin
    regNext = regQ;
    if (strb.load) regNext = wrData & WRITE_MASK;
    if (strb.clearTest) regNext[TEST_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regNext;
  end
endmodule

// File: rtl/rtcExtCtrlReg.sv
module rtcExtCtrlReg
  import rtcExtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             busStop,
  input  logic             busRestart,
  input  logic             busTimeout,
  output logic             testMode,
  output logic             alarmDaySel,
  output logic             updateMinute,
  output logic             timerRun,
  output logic [1:0]       timerSrc,
  output logic [7:0]       rdData
);
  ctrlStrobe_t      strb;
  logic [REG_W-1:0] regQ;

  rtcExtCtrl #(.EVT_N(NUM_EVT)) u_ctrl (
    .wrEn   (wrEn),
    .busEvt ({busTimeout, busRestart, busStop}),
    .strb   (strb)
  );

  rtcExtData u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .regQ   (regQ)
  );

  assign testMode     = regQ[TEST_BIT];
  assign alarmDaySel  = regQ[DAYSEL_BIT];
  assign updateMinute = regQ[MINUTE_BIT];
  assign timerRun     = regQ[RUN_BIT];
  assign timerSrc     = regQ[SRC_LSB +: SRC_W];
  assign rdData       = regQ;
endmodule

// File: rtl/rtcExtCtrlRegChk.sv
module rtcExtCtrlRegChk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       busStop,
  input logic       busRestart,
  input logic       busTimeout,
  input logic       testMode,
  input logic       alarmDaySel,
  input logic       updateMinute,
  input logic       timerRun,
  input logic [1:0] timerSrc,
  input logic [7:0] rdData
);
  logic anyEvt;
  assign anyEvt = busStop | busRestart | busTimeout;

  assert_reset_zero_R1: assert property (@(posedge clk) !rstN |=> rdData == 8'h00 || !rstN);

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !anyEvt |=> rdData == ($past(wrData) & 8'hF3));

  assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdData[3:2] == 2'b00);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && !anyEvt |=> $stable(rdData));

  assert_evt_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busStop || busRestart || busTimeout) |=> !testMode);

  assert_evt_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyEvt && !wrEn |=> rdData[6:0] == $past(rdData[6:0]));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyEvt && wrEn |=> rdData == ($past(wrData) & 8'h73));

  assert_fields_R9: assert property (@(posedge clk) disable iff (!rstN)
    {testMode, alarmDaySel, updateMinute, timerRun, timerSrc} ==
    {rdData[7:4], rdData[1:0]});
endmodule

bind rtcExtCtrlReg rtcExtCtrlRegChk u_chk (.*);

// File: tb/test_rtcExtCtrlReg.sv
module test_rtcExtCtrlReg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       busStop = 1'b0, busRestart = 1'b0, busTimeout = 1'b0;
  logic       testMode, alarmDaySel, updateMinute, timerRun;
  logic [1:0] timerSrc;
  logic [7:0] rdData;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  rtcExtCtrlReg i_rtcExtCtrlReg (.*);

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; busStop = 1'b0; busRestart = 1'b0; busTimeout = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    stepEdge();
  endtask

  function automatic logic [7:0] fieldsByte();
    return {testMode, alarmDaySel, updateMinute, timerRun, 2'b00, timerSrc};
  endfunction

  task automatic testReset();
    check("R1 rdData in reset", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;
    stepEdge();
    check("R1 rdData after reset", rdData, 8'h00);
    check("R1 fields after reset", fieldsByte(), 8'h00);
  endtask

  task automatic testWrite();
    writeReg(8'h72);
    check("R2 write 72", rdData, 8'h72);
    check("R9 fields for 72", fieldsByte(), 8'h72);
    check("R9 alarmDaySel", {7'd0, alarmDaySel}, 8'h01);
    check("R9 timerSrc second", {6'd0, timerSrc}, 8'h02);
    writeReg(8'h21);
    check("R2 write 21", rdData, 8'h21);
    check("R9 updateMinute", {7'd0, updateMinute}, 8'h01);
    check("R9 timerRun off", {7'd0, timerRun}, 8'h00);
  endtask

  task automatic testUnused();
    writeReg(8'hFF);
    check("R3 write FF reads F3", rdData, 8'hF3);
    writeReg(8'h0C);
    check("R3 write 0C reads 00", rdData, 8'h00);
  endtask

  task automatic testHold();
    writeReg(8'h53);
    wrData = 8'hAC;
    stepEdge();
    stepEdge();
    check("R4 hold without strobe", rdData, 8'h53);
  endtask

  task automatic testEvents();
    writeReg(8'hD1);
    busStop = 1'b1; stepEdge();
    check("R5 STOP clears test", rdData, 8'h51);
    writeReg(8'hB2);
    busRestart = 1'b1; stepEdge();
    check("R6 restart clears test", rdData, 8'h32);
    writeReg(8'hE3);
    busTimeout = 1'b1; stepEdge();
    check("R7 timeout clears test", rdData, 8'h63);
    check("R7 testMode low", {7'd0, testMode}, 8'h00);
    busStop = 1'b1; stepEdge();
    check("R5 STOP with test already 0", rdData, 8'h63);
  endtask

  task automatic testCollision();
    wrEn = 1'b1; wrData = 8'hF2; busStop = 1'b1;
    stepEdge();
    check("R8 write with STOP", rdData, 8'h72);
    wrEn = 1'b1; wrData = 8'h91; busTimeout = 1'b1; busRestart = 1'b1;
    stepEdge();
    check("R8 write with two events", rdData, 8'h11);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    testWrite();
    testUnused();
    testHold();
    testEvents();
    testCollision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule